// File: doc/BRIEF.md
# Serial NOR Flash Operation Sequencer

This block sits between a request port and a byte-level SPI shifter, and turns one request (read, fast read, page program or one of three erase sizes) into the full series of chip-select frames that a serial NOR flash needs. The SPI clock and bit shifting live in a separate byte engine. The sequencer starts one byte at a time through a start/done handshake and drives chip select itself.

Each accepted request first runs a busy check. The sequencer repeats two-byte status frames until the device reports that no write is in progress. If the device is still busy after a fixed number of status frames, the request ends with an error. Program and erase requests then get a one-byte write-enable frame. The main frame carries the opcode and a 24-bit address, most significant byte first. A fast read adds one dummy byte, reads return their bytes on a valid-qualified stream, programs pull bytes from a write-data input, and erases send no data. The request ends with a one-cycle done pulse and an error flag. Requests that fall outside the device, or that carry an unknown operation code, are refused before any frame is sent.

Top module: `spi_nor_sequencer`

## Requirements
- R1: After reset, req_ready is 1, cs_n is 1 and done is 0.
- R2: Every executed request begins with status frames. Each status frame is two bytes, opcode 0x05 and then a filler byte, and cs_n is high between frames. A further status frame follows as long as bit 0 of the returned status byte is 1.
- R3: If POLL_MAX status frames in a row all return bit 0 set, the request ends with done and err and sends no further frame.
- R4: Program and erase requests, and only these, send a frame that holds the single byte 0x06 between the last status frame and the main frame.
- R5: req_op selects the main-frame opcode: 0 normal read 0x03, 1 fast read 0x0B, 2 page program 0x02, 3 4 KiB erase 0x20, 4 32 KiB erase 0x52, 5 sector erase 0xD8.
- R6: The three main-frame bytes after the opcode are req_addr[23:16], req_addr[15:8] and req_addr[7:0], in that order.
- R7: A normal read frame has req_len data bytes after the address. A fast read frame puts one dummy byte before them. Every byte clocked in during the data phase appears once on rd_data with rd_valid high, in order.
- R8: A program frame sends req_len data bytes. Each byte is the value of wr_data in the cycle where wr_take is high, and wr_take is high once per byte.
- R9: An erase frame is exactly four bytes long, and req_len has no effect on it.
- R10: A request with req_op 6 or 7, or whose address plus length (taken as 1 for erases) is larger than DEV_SIZE, ends with done and err and produces no frame. A request that ends exactly at DEV_SIZE is executed.
- R11: A read or program with req_len 0 ends with done, without err and without any frame.
- R12: done lasts one cycle per request, and req_ready is low from the cycle after acceptance until the done cycle has passed.
- R13: xfer_start is a one-cycle pulse, and no new byte is started until xfer_done has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle; request accepted when both are high |
| req_op | input | 3 | Operation code (see R5) |
| req_addr | input | 24 | Byte address |
| req_len | input | LEN_W | Data byte count for read and program |
| wr_data | input | 8 | Next program byte |
| wr_take | output | 1 | Current wr_data byte is consumed |
| rd_valid | output | 1 | rd_data holds a read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Request finished |
| err | output | 1 | Request failed (valid with done) |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_start | output | 1 | Start one byte transfer |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_done | input | 1 | Byte transfer complete |
| xfer_rx | input | 8 | Byte shifted in |

## Verification
The embedded assertions check the cycle-level rules on every cycle: one-cycle done and start pulses, the ready drop after acceptance, the bound on the poll counter, and that read bytes only appear while a frame is open. The frame contents can only be shown by the bench scenarios. These cover the opcode and address order, the number of status frames for a given busy time, whether the write-enable frame is present, the dummy byte, the data values in both directions, and the range and timeout boundaries. A byte-level flash model in the bench logs every frame, and the bench compares the logged frames with values it computes from each request.

// File: rtl/spi_nor_sequencer.sv
module spi_nor_sequencer #(
  parameter longint unsigned DEV_SIZE = 64'h100000,
  parameter int              POLL_MAX = 100000,
  parameter int              LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             err,
  output logic             cs_n,
  output logic             xfer_start,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_done,
  input  logic [7:0]       xfer_rx
);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [7:0] C_WREN = 8'h06, C_STAT = 8'h05;

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_GAP, S_WREN, S_HDR, S_DUMMY, S_DATA, S_FIN} st_t;

  st_t              state, nxt;
  logic [2:0]       op;
  logic [23:0]      addr;
  logic [LEN_W-1:0] len, cnt;
  logic [1:0]       idx;
  logic [PW-1:0]    polls;
  logic             wait_x, err_r;
  logic [7:0]       opc;

  wire is_read  = (op == 3'd0) || (op == 3'd1);
  wire is_prog  = (op == 3'd2);
  wire is_erase = !is_read && !is_prog;

  wire             req_erase = (req_op >= 3'd3);
  wire [LEN_W-1:0] eff_len   = req_erase ? LEN_W'(1) : req_len;
  wire [32:0]      span      = 33'(req_addr) + 33'(eff_len);
  wire             req_bad   = (req_op > 3'd5) || (span > 33'(DEV_SIZE));
  wire             req_zero  = !req_erase && (req_len == '0);

  always_comb
    case (op)
      3'd0:    opc = 8'h03;
      3'd1:    opc = 8'h0B;
      3'd2:    opc = 8'h02;
      3'd3:    opc = 8'h20;
      3'd4:    opc = 8'h52;
      default: opc = 8'hD8;
    endcase

  wire active = (state == S_POLL) || (state == S_WREN) || (state == S_HDR) ||
                (state == S_DUMMY) || (state == S_DATA);

  assign req_ready  = (state == S_IDLE);
  assign cs_n       = !active;
  assign xfer_start = active && !wait_x;
  assign wr_take    = xfer_start && (state == S_DATA) && is_prog;
  assign done       = (state == S_FIN);
  assign err        = done && err_r;

  always_comb
    case (state)
      S_POLL:  xfer_tx = (idx == 2'd0) ? C_STAT : 8'h00;
      S_WREN:  xfer_tx = C_WREN;
      S_HDR:   xfer_tx = (idx == 2'd0) ? opc :
                         (idx == 2'd1) ? addr[23:16] :
                         (idx == 2'd2) ? addr[15:8] : addr[7:0];
      S_DATA:  xfer_tx = is_prog ? wr_data : 8'h00;
      default: xfer_tx = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      nxt      <= S_IDLE;
      op       <= '0;
      addr     <= '0;
      len      <= '0;
      cnt      <= '0;
      idx      <= '0;
      polls    <= '0;
      wait_x   <= 1'b0;
      err_r    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (xfer_start) wait_x <= 1'b1;
      case (state)
        S_IDLE:
          if (req_valid) begin
            op    <= req_op;
            addr  <= req_addr;
            len   <= req_len;
            idx   <= '0;
            polls <= '0;
            err_r <= req_bad;
            state <= (req_bad || req_zero) ? S_FIN : S_POLL;
          end
        S_GAP: state <= nxt;
        S_FIN: state <= S_IDLE;
        default:
          if (xfer_done && wait_x) begin
            wait_x <= 1'b0;
            case (state)
              S_POLL:
                if (idx == 2'd0) idx <= 2'd1;
                else begin
                  idx <= '0;
                  if (!xfer_rx[0]) begin
                    state <= S_GAP;
                    nxt   <= is_read ? S_HDR : S_WREN;
                  end else if (polls == PW'(POLL_MAX - 1)) begin
                    err_r <= 1'b1;
                    state <= S_FIN;
                  end else begin
                    polls <= polls + 1'b1;
                    state <= S_GAP;
                    nxt   <= S_POLL;
                  end
                end
              S_WREN: begin
                state <= S_GAP;
                nxt   <= S_HDR;
              end
              S_HDR: begin
                idx <= idx + 1'b1;
                cnt <= '0;
                if (idx == 2'd3)
                  state <= is_erase ? S_FIN : (op == 3'd1) ? S_DUMMY : S_DATA;
              end
              S_DUMMY: state <= S_DATA;
              default: begin
                if (is_read) begin
                  rd_valid <= 1'b1;
                  rd_data  <= xfer_rx;
                end
                cnt <= cnt + 1'b1;
                if (cnt == len - 1'b1) state <= S_FIN;
              end
            endcase
          end
      endcase
    end

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_start_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  assert_poll_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    polls < PW'(POLL_MAX));
  assert_rd_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!cs_n));
  assert_no_frame_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !xfer_start);
endmodule

// File: tb/test_spi_nor_sequencer.sv
`timescale 1ns/1ps
module test_spi_nor_sequencer;
  localparam longint unsigned SIZE = 64'h1000000;
  localparam int PM = 6;
  localparam int LW = 10;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [23:0]   req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [7:0]    wr_data = '0;
  logic          xfer_done = 1'b0;
  logic [7:0]    xfer_rx = '0;
  wire           req_ready, wr_take, rd_valid, done, err, cs_n, xfer_start;
  wire [7:0]     rd_data, xfer_tx;

  spi_nor_sequencer #(.DEV_SIZE(SIZE), .POLL_MAX(PM), .LEN_W(LW)) i_spi_nor_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
    .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
    .cs_n(cs_n), .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
    .xfer_rx(xfer_rx));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int busy_cfg = 0;

  int nframes = 0, nbytes = 0, nrd = 0, ndone = 0, last_err = 0, proto = 0, overlap = 0;
  logic [7:0] tx_log [0:4095];
  int         tx_frm [0:4095];
  int         flen   [0:1023];
  logic [7:0] rd_log [0:1023];

  function automatic logic [7:0] rpat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] wpat(input int i);
    return 8'((i * 13 + 5) & 255);
  endfunction
  function automatic logic [7:0] opcode_of(input int op);
    case (op)
      0: return 8'h03; 1: return 8'h0B; 2: return 8'h02;
      3: return 8'h20; 4: return 8'h52; default: return 8'hD8;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin : flash_model
    int busy_left = 0, cd = 0, fpos = 0, wr_idx = 0, haddr = 0;
    bit in_frame = 0, wel = 0;
    logic [7:0] f0 = 0, resp = 0;
    forever begin
      @(negedge clk);
      if (req_valid && req_ready) begin
        busy_left = busy_cfg;
        wr_idx = 0;
        wr_data <= wpat(0);
      end
      if (cs_n) begin
        if (in_frame) begin
          flen[nframes] = fpos;
          nframes++;
        end
        in_frame = 0;
        fpos = 0;
      end
      if (done) begin ndone++; last_err = err; end
      if (rd_valid) begin rd_log[nrd] = rd_data; nrd++; end
      if (wr_take) begin wr_idx++; wr_data <= wpat(wr_idx); end
      xfer_done <= 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin xfer_done <= 1'b1; xfer_rx <= resp; end
      end
      if (xfer_start) begin
        if (cd > 0) overlap++;
        in_frame = 1;
        tx_log[nbytes] = xfer_tx;
        tx_frm[nbytes] = nframes;
        nbytes++;
        resp = 8'h00;
        if (fpos == 0) begin
          f0 = xfer_tx;
          if (xfer_tx == 8'h06) wel = 1;
          if (xfer_tx == 8'h02 || xfer_tx == 8'h20 || xfer_tx == 8'h52 || xfer_tx == 8'hD8) begin
            if (!wel) proto++;
            wel = 0;
          end
        end else if (f0 == 8'h05 && fpos == 1) begin
          resp = {6'b0, wel, busy_left > 0};
          if (busy_left > 0) busy_left--;
        end
        if (fpos >= 1 && fpos <= 3) haddr = (haddr << 8) | int'(xfer_tx);
        if (f0 == 8'h03 && fpos >= 4) resp = rpat(haddr + fpos - 4);
        if (f0 == 8'h0B && fpos >= 5) resp = rpat(haddr + fpos - 5);
        cd = 2;
        fpos++;
      end
    end
  end

  task automatic run(input int op, input int addr, input int len, input int busy);
    int f_b = nframes, b_b = nbytes, r_b = nrd, d_b = ndone, p_b = proto;
    int waited = 0, eff, stat, k, mf, mb;
    bit bad, zero, tmo;
    string tag;
    @(posedge clk); #1;
    busy_cfg = busy;
    req_op = 3'(op); req_addr = 24'(addr); req_len = LW'(len); req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R12", "ready after accept", req_ready, 0);
    while (ndone == d_b && waited < 3000) begin @(negedge clk); waited++; end
    repeat (3) @(negedge clk);
    eff  = (op >= 3) ? 1 : len;
    bad  = (op > 5) || (longint'(addr) + eff > SIZE);
    zero = !bad && op <= 2 && len == 0;
    tmo  = !bad && !zero && busy >= PM;
    chk(ndone - d_b == 1, "R12", "done pulses", ndone - d_b, 1);
    if (bad || zero) begin
      tag = bad ? "R10" : "R11";
      chk(nframes == f_b, tag, "frames", nframes - f_b, 0);
      chk(last_err == int'(bad), tag, "err", last_err, bad);
    end else if (tmo) begin
      chk(nframes - f_b == PM, "R3", "status frames", nframes - f_b, PM);
      chk(last_err == 1, "R3", "err", last_err, 1);
    end else begin
      stat = busy + 1;
      k = b_b;
      for (int f = 0; f < stat; f++) begin
        chk(flen[f_b + f] == 2 && tx_log[k] == 8'h05, "R2", "status frame",
            {flen[f_b + f], tx_log[k]}, {2, 8'h05});
        k += 2;
      end
      mf = f_b + stat;
      if (op >= 2) begin
        chk(flen[mf] == 1 && tx_log[k] == 8'h06, "R4", "wren frame", tx_log[k], 8'h06);
        k++; mf++;
      end else
        chk(tx_log[k] != 8'h06, "R4", "no wren on read", tx_log[k], opcode_of(op));
      chk(nframes - f_b == mf - f_b + 1, "R2", "frame count", nframes - f_b, mf - f_b + 1);
      chk(tx_frm[k] == mf && tx_log[k] == opcode_of(op), "R5", "opcode", tx_log[k], opcode_of(op));
      chk({tx_log[k+1], tx_log[k+2], tx_log[k+3]} == 24'(addr), "R6", "address",
          {tx_log[k+1], tx_log[k+2], tx_log[k+3]}, addr);
      mb = 4 + (op == 1) + ((op <= 2) ? len : 0);
      chk(flen[mf] == mb, op >= 3 ? "R9" : "R7", "main frame length", flen[mf], mb);
      if (op <= 1) begin
        chk(nrd - r_b == len, "R7", "read count", nrd - r_b, len);
        for (int i = 0; i < len; i++)
          chk(rd_log[r_b + i] == rpat(addr + i), "R7", "read byte", rd_log[r_b + i], rpat(addr + i));
      end
      if (op == 2)
        for (int i = 0; i < len; i++)
          chk(tx_log[k + 4 + i] == wpat(i), "R8", "program byte", tx_log[k + 4 + i], wpat(i));
      chk(last_err == 0, "R2", "err", last_err, 0);
    end
    chk(proto == p_b, "R4", "write without enable", proto - p_b, 0);
    chk(overlap == 0, "R13", "overlapping starts", overlap, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && cs_n == 1'b1 && done == 1'b0, "R1", "reset state",
        {req_ready, cs_n, done}, 3'b110);
    for (int op = 0; op < 6; op++)
      foreach (busy_list[b])
        for (int l = 1; l <= 5; l += 4)
          run(op, 24'hA5C3F0 + op * 24'h010203 + l, l * 2 + op, busy_list[b]);
    run(0, 24'hFFFFFC, 4, 0);
    run(1, 24'hFFFFFC, 5, 0);
    run(2, 24'hFFFFF0, 17, 1);
    run(3, 24'hFFFFFF, 900, 0);
    run(6, 24'h000100, 1, 0);
    run(7, 24'h000100, 1, 0);
    run(0, 24'h001000, 0, 0);
    run(2, 24'h001000, 0, 0);
    run(0, 24'h123456, 3, PM - 1);
    run(5, 24'h123456, 3, PM);
    run(2, 24'h010000, 2, PM + 3);
    run(4, 24'h00FFFF, 0, 2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int busy_list [3] = '{0, 1, 3};

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule